// File: doc/BRIEF.md
# Zero-Overhead Repeat Loop Sequencer

This block produces the program counter of a processor that can repeat a block of code with no branch instruction at its end. It holds a loop start address, a loop end address, a remaining-pass count and a 32-bit status word. One status bit marks a repeat block as active. Every cycle in which an instruction retires, the block looks at the address just executed. From that address, the branch outcome and the loop state it updates the count and the active bit, then selects the next fetch address.

The same step also watches for a debugger breakpoint. It compares the executed address with a break address supplied from outside. If they match while the debug-enable bit is set, control goes to a fixed trap vector and the status word is rewritten. The loop registers and the status word are loaded through a one-word write port. That port stands for the executing instruction's own register writes, so a write that lands in a retiring cycle belongs to that instruction.

Top module: `zol_seq`

## Requirements
- R1: After reset the program counter, loop start, loop end, count and status word are all zero, and `dbg_trap_o` is low.
- R2: When `wr_en_i` is high, `wr_data_i` is stored at the next edge into the register named by `wr_sel_i`: 0 = loop start, 1 = loop end, 2 = count, 3 = status. When `retire_i` is low, the program counter and the loop state keep their values, apart from such writes.
- R3: When an instruction retires at the loop end address while the count is nonzero or the active bit (status bit 3) is set, the count is decremented. It stops at zero and never wraps.
- R4: The loop-back test uses the count as it stood before the instruction. If the active bit was set, that count was nonzero and the executed address equals the loop end, the next PC is the loop start. This holds even when the instruction writes the count in the same cycle.
- R5: The active bit is cleared when it was set, the executed address is the loop end and the count after this cycle's update is zero.
- R6: A taken branch (`br_taken_i` with `br_target_i`) sets the next PC ahead of loop-back. The count is still updated as in R3.
- R7: When no other rule applies, a retiring instruction advances the PC by 8.
- R8: When a retiring instruction's address equals `brk_addr_i` and the debug-enable bit (status bit 1) is set after this cycle's updates, `dbg_trap_o` is high in that cycle. The next PC is then 0xFFFFF128, and the status word keeps only the supervisor bit (bit 0) and gains the debug-state bit (bit 2). All other status bits clear.
- R9: A breakpoint trap does not change the count update of that cycle.
- R10: A count written by a retiring instruction replaces the decremented value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | An instruction at `pc_o` completes this cycle |
| br_taken_i | input | 1 | The retiring instruction branches |
| br_target_i | input | 32 | Branch destination |
| brk_addr_i | input | 32 | Instruction break address |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 start, 1 end, 2 count, 3 status |
| wr_data_i | input | 32 | Write value |
| pc_o | output | 32 | Current program counter |
| count_o | output | 32 | Remaining repeat count |
| status_o | output | 32 | Status word |
| dbg_trap_o | output | 1 | Breakpoint trap taken this cycle |

## Verification
Errors in the loop registers or the active bit show up at `pc_o` one edge after the affected instruction retires. The symptom is a loop-back that comes too early or too late, so the PC walk has one pass too many or too few. Tests walk complete loops address by address and check the count and status word at each pass through the loop end. The pre-instruction count rule is only visible when the instruction writes the count in the same cycle, so that case has its own test. Trap tests check that the vector and the rewritten status appear one edge after `dbg_trap_o`, and that the count still moves in that cycle.

// File: rtl/zol_pkg.sv
package zol_pkg;

    localparam int unsigned AW     = 32;
    localparam int unsigned SEL_W  = 2;

    localparam int unsigned SM_BIT = 0;
    localparam int unsigned DB_BIT = 1;
    localparam int unsigned DS_BIT = 2;
    localparam int unsigned RP_BIT = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_START  = 2'd0,
        SEL_END    = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_STATUS = 2'd3
    } zol_sel_e;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] rstart;
        logic [AW-1:0] rend;
        logic [AW-1:0] cnt;
        logic [AW-1:0] psw;
    } zol_state_t;

endpackage

// File: rtl/zol_count.sv
module zol_count
    import zol_pkg::*;
(
    input  logic [AW-1:0] cnt_q,
    input  logic          at_end,
    input  logic          rp_q,
    input  logic          cnt_wr,
    input  logic [AW-1:0] wr_data,
    output logic          pre_nz,
    output logic [AW-1:0] cnt_d
);

    logic [AW-1:0] cnt_dec;

    always_comb begin
        pre_nz  = |cnt_q;
        cnt_dec = cnt_q;
        if (at_end && (pre_nz || rp_q)) begin
            cnt_dec = pre_nz ? (cnt_q - 1'b1) : '0;
        end
        cnt_d = cnt_wr ? wr_data : cnt_dec;
    end

endmodule

// File: rtl/zol_status.sv
module zol_status
    import zol_pkg::*;
(
    input  logic          retire,
    input  logic          at_end,
    input  logic [AW-1:0] psw_q,
    input  logic          psw_wr,
    input  logic [AW-1:0] wr_data,
    input  logic [AW-1:0] cnt_new,
    input  logic [AW-1:0] pc_q,
    input  logic [AW-1:0] brk_addr,
    output logic          rp_q,
    output logic          trap,
    output logic [AW-1:0] psw_d
);

    localparam logic [AW-1:0] SM_MASK = AW'(1) << SM_BIT;
    localparam logic [AW-1:0] DS_MASK = AW'(1) << DS_BIT;

    logic [AW-1:0] psw_x;

    always_comb begin
        rp_q  = psw_q[RP_BIT];
        psw_x = psw_wr ? wr_data : psw_q;
        if (at_end && rp_q && (cnt_new == '0)) begin
            psw_x[RP_BIT] = 1'b0;
        end
        trap  = retire && (pc_q == brk_addr) && psw_x[DB_BIT];
        psw_d = trap ? ((psw_x & SM_MASK) | DS_MASK) : psw_x;
    end

endmodule

// File: rtl/zol_nextpc.sv
module zol_nextpc
    import zol_pkg::*;
#(
    parameter int unsigned   PC_STEP  = 8,
    parameter logic [AW-1:0] TRAP_VEC = 32'hFFFF_F128
) (
    input  logic          retire,
    input  logic          at_end,
    input  logic          rp_q,
    input  logic          pre_nz,
    input  logic          br_taken,
    input  logic [AW-1:0] br_target,
    input  logic [AW-1:0] rstart,
    input  logic          trap,
    input  logic [AW-1:0] pc_q,
    output logic [AW-1:0] pc_d
);

    localparam logic [AW-1:0] STEP = AW'(PC_STEP);

    logic loop_back;

    always_comb begin
        loop_back = at_end && rp_q && pre_nz;
        if (trap) begin
            pc_d = TRAP_VEC;
        end else if (!retire) begin
            pc_d = pc_q;
        end else if (br_taken) begin
            pc_d = br_target;
        end else if (loop_back) begin
            pc_d = rstart;
        end else begin
            pc_d = pc_q + STEP;
        end
    end

endmodule

// File: rtl/zol_seq.sv
module zol_seq
    import zol_pkg::*;
#(
    parameter int unsigned   PC_STEP  = 8,
    parameter logic [AW-1:0] TRAP_VEC = 32'hFFFF_F128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic             br_taken_i,
    input  logic [AW-1:0]    br_target_i,
    input  logic [AW-1:0]    brk_addr_i,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [AW-1:0]    wr_data_i,
    output logic [AW-1:0]    pc_o,
    output logic [AW-1:0]    count_o,
    output logic [AW-1:0]    status_o,
    output logic             dbg_trap_o
);

    zol_state_t st_d, st_q;

    logic          at_end;
    logic          pre_nz;
    logic          rp_q;
    logic          trap;
    logic          cnt_wr;
    logic          psw_wr;
    logic [AW-1:0] cnt_nx;
    logic [AW-1:0] psw_nx;
    logic [AW-1:0] pc_nx;

    assign at_end = retire_i && (st_q.pc == st_q.rend);
    assign cnt_wr = wr_en_i && (zol_sel_e'(wr_sel_i) == SEL_COUNT);
    assign psw_wr = wr_en_i && (zol_sel_e'(wr_sel_i) == SEL_STATUS);

    zol_count u_count (
        .cnt_q   (st_q.cnt),
        .at_end  (at_end),
        .rp_q    (rp_q),
        .cnt_wr  (cnt_wr),
        .wr_data (wr_data_i),
        .pre_nz  (pre_nz),
        .cnt_d   (cnt_nx)
    );

    zol_status u_status (
        .retire   (retire_i),
        .at_end   (at_end),
        .psw_q    (st_q.psw),
        .psw_wr   (psw_wr),
        .wr_data  (wr_data_i),
        .cnt_new  (cnt_nx),
        .pc_q     (st_q.pc),
        .brk_addr (brk_addr_i),
        .rp_q     (rp_q),
        .trap     (trap),
        .psw_d    (psw_nx)
    );

    zol_nextpc #(
        .PC_STEP  (PC_STEP),
        .TRAP_VEC (TRAP_VEC)
    ) u_nextpc (
        .retire    (retire_i),
        .at_end    (at_end),
        .rp_q      (rp_q),
        .pre_nz    (pre_nz),
        .br_taken  (br_taken_i),
        .br_target (br_target_i),
        .rstart    (st_q.rstart),
        .trap      (trap),
        .pc_q      (st_q.pc),
        .pc_d      (pc_nx)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en_i && (zol_sel_e'(wr_sel_i) == SEL_START)) begin
            st_d.rstart = wr_data_i;
        end
        if (wr_en_i && (zol_sel_e'(wr_sel_i) == SEL_END)) begin
            st_d.rend = wr_data_i;
        end
        st_d.cnt = cnt_nx;
        st_d.psw = psw_nx;
        st_d.pc  = pc_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o       = st_q.pc;
    assign count_o    = st_q.cnt;
    assign status_o   = st_q.psw;
    assign dbg_trap_o = trap;

endmodule

// File: rtl/zol_seq_chk.sv
module zol_seq_chk
    import zol_pkg::*;
#(
    parameter logic [AW-1:0] TRAP_VEC = 32'hFFFF_F128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             retire_i,
    input logic             br_taken_i,
    input logic [AW-1:0]    br_target_i,
    input logic             wr_en_i,
    input logic [SEL_W-1:0] wr_sel_i,
    input logic [AW-1:0]    pc_o,
    input logic [AW-1:0]    count_o,
    input logic [AW-1:0]    status_o,
    input logic             dbg_trap_o
);

    localparam logic [AW-1:0] KEEP = (AW'(1) << SM_BIT) | (AW'(1) << DS_BIT);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire_i && !wr_en_i) |=> ($stable(pc_o) && $stable(count_o) && $stable(status_o)));

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && !(wr_en_i && wr_sel_i == SEL_COUNT))
        |=> ((count_o == $past(count_o)) || (count_o == $past(count_o) - 1'b1)));

    p_branch_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && br_taken_i && !dbg_trap_o) |=> (pc_o == $past(br_target_i)));

    p_trap_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_trap_o |=> ((pc_o == TRAP_VEC) && status_o[DS_BIT] && ((status_o & ~KEEP) == '0)));

    p_trap_needs_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_trap_o |-> retire_i);

endmodule

bind zol_seq zol_seq_chk #(.TRAP_VEC(TRAP_VEC)) u_zol_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .retire_i    (retire_i),
    .br_taken_i  (br_taken_i),
    .br_target_i (br_target_i),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .pc_o        (pc_o),
    .count_o     (count_o),
    .status_o    (status_o),
    .dbg_trap_o  (dbg_trap_o)
);

// File: tb/zol_seq_bench.sv
module zol_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire_i = 1'b0;
    logic        br_taken_i = 1'b0;
    logic [31:0] br_target_i = '0;
    logic [31:0] brk_addr_i = 32'hFFFF_FFFC;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] pc_o, count_o, status_o;
    logic        dbg_trap_o;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    zol_seq u_zol_seq (
        .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .br_taken_i(br_taken_i),
        .br_target_i(br_target_i), .brk_addr_i(brk_addr_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .pc_o(pc_o), .count_o(count_o),
        .status_o(status_o), .dbg_trap_o(dbg_trap_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; retire_i = 0; br_taken_i = 0; wr_en_i = 0;
        brk_addr_i = 32'hFFFF_FFFC;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive one cycle at the falling edge, let the rising edge land, sample after it
    task automatic cyc(input logic ret, input logic br, input logic [31:0] tgt,
                       input logic we, input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        retire_i = ret; br_taken_i = br; br_target_i = tgt;
        wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
        @(posedge clk);
        #2;
        retire_i = 0; br_taken_i = 0; wr_en_i = 0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        cyc(1'b0, 1'b0, '0, 1'b1, sel, d);
    endtask

    task automatic step();
        cyc(1'b1, 1'b0, '0, 1'b0, 2'd0, '0);
    endtask

    task automatic setup_loop(input logic [31:0] s, input logic [31:0] e,
                              input logic [31:0] c, input logic [31:0] psw);
        wr(2'd0, s); wr(2'd1, e); wr(2'd2, c); wr(2'd3, psw);
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check("R1 pc", pc_o, 32'h0);
        check("R1 count", count_o, 32'h0);
        check("R1 status", status_o, 32'h0);
        check("R1 trap", {31'b0, dbg_trap_o}, 32'h0);
    endtask

    task automatic t_sequential();
        do_reset();
        step(); check("R7 pc+8", pc_o, 32'h8);
        step(); check("R7 pc+16", pc_o, 32'h10);
        cyc(1'b0, 1'b0, '0, 1'b0, 2'd0, '0);
        check("R2 hold pc", pc_o, 32'h10);
        wr(2'd2, 32'd7);
        check("R2 count write", count_o, 32'd7);
        check("R2 pc held on write", pc_o, 32'h10);
    endtask

    task automatic t_loop();
        do_reset();
        setup_loop(32'h10, 32'h18, 32'd2, 32'h8);
        check("R2 status write", status_o, 32'h8);
        step(); step(); step();
        check("R7 reach end", pc_o, 32'h18);
        step();
        check("R4 loop back pass1", pc_o, 32'h10);
        check("R3 dec pass1", count_o, 32'd1);
        check("R5 rp kept", status_o, 32'h8);
        step(); step();
        check("R4 loop back pass2", pc_o, 32'h10);
        check("R3 dec pass2", count_o, 32'd0);
        check("R5 rp cleared", status_o, 32'h0);
        step(); step();
        check("R4 loop exit", pc_o, 32'h20);
        check("R3 no dec idle", count_o, 32'd0);
    endtask

    task automatic t_floor();
        do_reset();
        setup_loop(32'h40, 32'h8, 32'd0, 32'h8);
        step(); step();
        check("R3 floor zero", count_o, 32'd0);
        check("R5 rp clear at zero", status_o, 32'h0);
        check("R4 no loop at zero", pc_o, 32'h10);
    endtask

    task automatic t_precount();
        do_reset();
        setup_loop(32'h20, 32'h8, 32'd3, 32'h8);
        step();
        cyc(1'b1, 1'b0, '0, 1'b1, 2'd2, 32'd0);
        check("R4 pre-count loop back", pc_o, 32'h20);
        check("R10 write zero", count_o, 32'd0);
        check("R5 rp cleared by written zero", status_o, 32'h0);
        do_reset();
        setup_loop(32'h20, 32'h8, 32'd3, 32'h8);
        step();
        cyc(1'b1, 1'b0, '0, 1'b1, 2'd2, 32'd5);
        check("R10 write wins", count_o, 32'd5);
        check("R10 loop back", pc_o, 32'h20);
        check("R10 rp kept", status_o, 32'h8);
    endtask

    task automatic t_branch();
        do_reset();
        setup_loop(32'h20, 32'h8, 32'd2, 32'h8);
        step();
        cyc(1'b1, 1'b1, 32'h100, 1'b0, 2'd0, '0);
        check("R6 branch first", pc_o, 32'h100);
        check("R6 count still dec", count_o, 32'd1);
    endtask

    task automatic t_trap();
        do_reset();
        setup_loop(32'h20, 32'h8, 32'd2, 32'h2B);
        brk_addr_i = 32'h8;
        step();
        check("R8 no trap off-address", pc_o, 32'h8);
        @(negedge clk);
        retire_i = 1'b1;
        #1;
        check("R8 trap flag", {31'b0, dbg_trap_o}, 32'h1);
        @(posedge clk);
        #2;
        retire_i = 1'b0;
        check("R8 trap vector", pc_o, 32'hFFFF_F128);
        check("R8 trap status", status_o, 32'h5);
        check("R9 count moves", count_o, 32'd1);
        do_reset();
        wr(2'd3, 32'h1);
        brk_addr_i = 32'h8;
        step();
        @(negedge clk);
        retire_i = 1'b1;
        #1;
        check("R8 no trap without DB", {31'b0, dbg_trap_o}, 32'h0);
        @(posedge clk);
        #2;
        retire_i = 1'b0;
        check("R8 sequential without DB", pc_o, 32'h10);
        check("R8 status untouched", status_o, 32'h1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_reset();
        t_sequential();
        t_loop();
        t_floor();
        t_precount();
        t_branch();
        t_trap();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule